// File: doc/BRIEF.md
# Eight-Phase Differential PSK Sample Generator

This block turns a serial stream of already-scrambled data into the digital line samples of an eight-phase differential phase-shift-keyed signal at 4800 b/s. Incoming bits are accepted through a valid/ready handshake and packed into three-bit symbols (tribits). Each tribit selects a phase advance in steps of 45 degrees. That advance is added, modulo eight, to a running absolute phase held as a three-bit index.

A sample strobe at 9.6 kHz paces the output. Every strobe produces one signed 8-bit sample, and six strobes make one signaling interval, which gives 1600 baud. Each symbol owns a shaped envelope of twelve samples, drawn from one of eight groups chosen by its absolute phase. Envelopes of neighbouring symbols overlap by half. Each output sample is therefore the saturated sum of the second half of the previous symbol's group and the first half of the current one. If no complete tribit is waiting when a symbol must start, the block sends a zero-degree advance and flags an underrun for that symbol.

Top module: `dpsk8_tx`

## Requirements
- R1: After reset, sample_o, sample_vld_o, sym_start_o and underrun_o are 0 and bit_rdy_o is 1. The absolute phase index is 0, and no earlier symbol exists.
- R2: A bit is taken on a clock edge where bit_vld_i and bit_rdy_o are both 1. The first of three taken bits becomes the leftmost (most significant) tribit digit. While three bits are held, bit_rdy_o is 0 and offered bits are not taken.
- R3: Each tribit gives a phase advance k, in units of 45 degrees: 001→0, 000→1, 010→2, 011→3, 111→4, 110→5, 100→6, 101→7. The new absolute phase is (old + k) mod 8.
- R4: A symbol starts on the first strobe after reset and then on every sixth strobe. sym_start_o marks the first of its six samples.
- R5: Sample k (0..11) of the group for absolute phase p is floor(C[(2p+3k) mod 16] * W[k] / 256). C[i] = round(127·cos(i·22.5°)). W[k] = min(256, 32+64k, 32+64(11−k)).
- R6: The output at slot s (0..5) of a symbol is the sum of group sample s+6 of the previous symbol's phase and group sample s of the current phase, saturated to −128..127. The first symbol after reset has no previous part.
- R7: If fewer than three bits are held when a symbol starts, code 001 is used and underrun_o is 1 for all six of that symbol's samples. Any held bits stay and lead the next tribit. underrun_o is 0 for symbols fed by a full tribit.
- R8: The sample for a strobe on a clock edge is on sample_o after that edge. sample_vld_o is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Data bit offered |
| bit_rdy_o | output | 1 | Block can take a data bit |
| smp_stb_i | input | 1 | One-cycle sample strobe (9.6 kHz) |
| sample_o | output | 8 | Signed line sample |
| sample_vld_o | output | 1 | sample_o updated this cycle |
| sym_start_o | output | 1 | Sample is the first of a symbol |
| underrun_o | output | 1 | Current symbol carries filler code |

## Verification
The assertions check the following on every cycle:
- the valid pulse follows each strobe one-for-one;
- the slot counter wraps after six strobes;
- the phase changes only at a symbol start;
- held bits stay frozen while the packer is full;
- a start without a full tribit sets the underrun flag.

Only the bench scenarios can show that the numbers are right. They cover the code-to-phase map, the bit order inside a tribit, the twelve-sample group values, the overlap sum with its saturation, and the reuse of partial tribits after an underrun. The bench checks these against a model that builds the cosine, window and phase sequence from the requirements on its own.

// File: rtl/dpsk8_pkg.sv
package dpsk8_pkg;

    localparam int SMP_W     = 8;
    localparam int HALF_LEN  = 6;
    localparam int ENV_LEN   = 2 * HALF_LEN;
    localparam int PH_W      = 3;
    localparam int ANG_STEPS = 16;
    localparam int WIN_SHIFT = 8;
    localparam int WIN_PEAK  = 1 << WIN_SHIFT;
    localparam int WIN_BASE  = 32;
    localparam int WIN_RISE  = 64;
    localparam int SLOT_W    = $clog2(HALF_LEN);
    localparam int SMP_MAX   = (1 << (SMP_W - 1)) - 1;
    localparam int SMP_MIN   = -(1 << (SMP_W - 1));

    typedef logic [2:0]              tribit_t;
    typedef logic [PH_W-1:0]         phase_t;
    typedef logic signed [SMP_W-1:0] sample_t;
    typedef logic [SLOT_W-1:0]       slot_t;

    typedef enum logic [PH_W-1:0] {
        ADV_0   = 3'd0, ADV_45  = 3'd1, ADV_90  = 3'd2, ADV_135 = 3'd3,
        ADV_180 = 3'd4, ADV_225 = 3'd5, ADV_270 = 3'd6, ADV_315 = 3'd7
    } advance_e;

    typedef struct packed {
        phase_t head_ph;
        phase_t tail_ph;
        logic   tail_on;
        logic   start;
        logic   filler;
        slot_t  slot;
    } sym_ctx_t;

    localparam tribit_t FILL_CODE = 3'b001;

    function automatic advance_e step_of(tribit_t t);
        case (t)
            3'b001:  return ADV_0;
            3'b000:  return ADV_45;
            3'b010:  return ADV_90;
            3'b011:  return ADV_135;
            3'b111:  return ADV_180;
            3'b110:  return ADV_225;
            3'b100:  return ADV_270;
            default: return ADV_315;
        endcase
    endfunction

    function automatic int cos_mag(int j);
        case (j)
            0:       return 127;
            1:       return 117;
            2:       return 90;
            3:       return 49;
            default: return 0;
        endcase
    endfunction

    function automatic int cos_q(int i);
        if (i <= 4)       return cos_mag(i);
        else if (i <= 8)  return -cos_mag(8 - i);
        else if (i <= 12) return -cos_mag(i - 8);
        else              return cos_mag(ANG_STEPS - i);
    endfunction

    function automatic int win_of(int k);
        int up;
        int dn;
        int m;
        up = WIN_BASE + WIN_RISE * k;
        dn = WIN_BASE + WIN_RISE * (ENV_LEN - 1 - k);
        m  = (up < dn) ? up : dn;
        return (m > WIN_PEAK) ? WIN_PEAK : m;
    endfunction

    function automatic int group_val(phase_t p, int k);
        int idx;
        idx = (2 * int'(p) + 3 * k) % ANG_STEPS;
        return (cos_q(idx) * win_of(k)) >>> WIN_SHIFT;
    endfunction

    function automatic sample_t sat_smp(int v);
        if (v > SMP_MAX)      return sample_t'(SMP_MAX);
        else if (v < SMP_MIN) return sample_t'(SMP_MIN);
        else                  return sample_t'(v);
    endfunction

endpackage

// File: rtl/dpsk8_packer.sv
module dpsk8_packer
    import dpsk8_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_i,
    input  logic    bit_vld_i,
    output logic    bit_rdy_o,
    input  logic    take_i,
    output logic    avail_o,
    output tribit_t tribit_o
);
    localparam logic [1:0] FULL = 2'd3;

    logic [1:0] cnt_q;
    tribit_t    sh_q;
    logic       accept;

    assign bit_rdy_o = (cnt_q != FULL);
    assign avail_o   = (cnt_q == FULL);
    assign tribit_o  = sh_q;
    assign accept    = bit_vld_i && bit_rdy_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (take_i && avail_o) begin
            cnt_q <= '0;
        end else if (accept) begin
            sh_q  <= {sh_q[1:0], bit_i};
            cnt_q <= cnt_q + 2'd1;
        end
    end

    // R2: a full packer keeps its bits until a symbol takes them
    a_r2_hold_full: assert property (@(posedge clk) disable iff (rst)
        (avail_o && !take_i) |=> (avail_o && $stable(sh_q)));

endmodule

// File: rtl/dpsk8_phase_seq.sv
module dpsk8_phase_seq
    import dpsk8_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     strobe_i,
    input  logic     avail_i,
    input  tribit_t  tribit_i,
    output logic     take_o,
    output sym_ctx_t ctx_o
);
    slot_t  slot_q;
    phase_t cur_q;
    phase_t prev_q;
    logic   ok_q;
    logic   started_q;
    logic   fill_q;

    logic    start;
    tribit_t code;
    phase_t  nxt;

    assign start  = strobe_i && (slot_q == '0);
    assign take_o = start;
    assign code   = avail_i ? tribit_i : FILL_CODE;
    assign nxt    = cur_q + phase_t'(step_of(code));

    always_comb begin
        ctx_o.head_ph = start ? nxt : cur_q;
        ctx_o.tail_ph = start ? cur_q : prev_q;
        ctx_o.tail_on = start ? started_q : ok_q;
        ctx_o.start   = start;
        ctx_o.filler  = start ? !avail_i : fill_q;
        ctx_o.slot    = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q    <= '0;
            cur_q     <= '0;
            prev_q    <= '0;
            ok_q      <= 1'b0;
            started_q <= 1'b0;
            fill_q    <= 1'b0;
        end else if (strobe_i) begin
            slot_q <= (slot_q == slot_t'(HALF_LEN - 1)) ? '0 : slot_q + slot_t'(1);
            if (start) begin
                cur_q     <= nxt;
                prev_q    <= cur_q;
                ok_q      <= started_q;
                started_q <= 1'b1;
                fill_q    <= !avail_i;
            end
        end
    end

    // R4: six strobes per symbol
    a_r4_slot_wrap: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && slot_q == slot_t'(HALF_LEN - 1)) |=> (slot_q == '0));

    // R3: absolute phase moves only when a symbol starts
    a_r3_phase_still: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(cur_q));

    // R7: a start without a full tribit marks the symbol as filler
    a_r7_fill_flag: assert property (@(posedge clk) disable iff (rst)
        (start && !avail_i) |=> fill_q);

endmodule

// File: rtl/dpsk8_mixer.sv
module dpsk8_mixer
    import dpsk8_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     strobe_i,
    input  sym_ctx_t ctx_i,
    output sample_t  sample_o,
    output logic     vld_o,
    output logic     first_o,
    output logic     under_o
);
    int      tail_v;
    int      head_v;
    sample_t mix;

    always_comb begin
        tail_v = ctx_i.tail_on ? group_val(ctx_i.tail_ph, int'(ctx_i.slot) + HALF_LEN) : 0;
        head_v = group_val(ctx_i.head_ph, int'(ctx_i.slot));
        mix    = sat_smp(tail_v + head_v);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_o <= '0;
            vld_o    <= 1'b0;
            first_o  <= 1'b0;
            under_o  <= 1'b0;
        end else begin
            vld_o   <= strobe_i;
            first_o <= strobe_i && ctx_i.start;
            if (strobe_i) begin
                sample_o <= mix;
                under_o  <= ctx_i.filler;
            end
        end
    end

    // R8: one valid pulse per strobe
    a_r8_vld_pulse: assert property (@(posedge clk) disable iff (rst)
        strobe_i |=> vld_o);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> !vld_o);
    // R4: a symbol mark always rides on a valid sample
    a_r4_first_valid: assert property (@(posedge clk) disable iff (rst)
        first_o |-> vld_o);

endmodule

// File: rtl/dpsk8_tx.sv
module dpsk8_tx
    import dpsk8_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_i,
    input  logic                    bit_vld_i,
    output logic                    bit_rdy_o,
    input  logic                    smp_stb_i,
    output logic signed [SMP_W-1:0] sample_o,
    output logic                    sample_vld_o,
    output logic                    sym_start_o,
    output logic                    underrun_o
);
    logic     take;
    logic     avail;
    tribit_t  tribit;
    sym_ctx_t ctx;

    dpsk8_packer u_packer (
        .clk       (clk),
        .rst       (rst),
        .bit_i     (bit_i),
        .bit_vld_i (bit_vld_i),
        .bit_rdy_o (bit_rdy_o),
        .take_i    (take),
        .avail_o   (avail),
        .tribit_o  (tribit)
    );

    dpsk8_phase_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (smp_stb_i),
        .avail_i  (avail),
        .tribit_i (tribit),
        .take_o   (take),
        .ctx_o    (ctx)
    );

    dpsk8_mixer u_mix (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (smp_stb_i),
        .ctx_i    (ctx),
        .sample_o (sample_o),
        .vld_o    (sample_vld_o),
        .first_o  (sym_start_o),
        .under_o  (underrun_o)
    );

endmodule

// File: tb/dpsk8_tx_bench.sv
module dpsk8_tx_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_i = 1'b0;
    logic bit_vld_i = 1'b0;
    logic smp_stb_i = 1'b0;
    logic bit_rdy_o;
    logic signed [7:0] sample_o;
    logic sample_vld_o, sym_start_o, underrun_o;

    dpsk8_tx u_dpsk8_tx (
        .clk(clk), .rst(rst), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
        .bit_rdy_o(bit_rdy_o), .smp_stb_i(smp_stb_i), .sample_o(sample_o),
        .sample_vld_o(sample_vld_o), .sym_start_o(sym_start_o),
        .underrun_o(underrun_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int    smp;
        bit    first;
        bit    under;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int total = 0;
    int bad = 0;
    int m_phase = 0;
    bit m_ok = 0;
    int sat_seen = 0;

    function automatic int ref_cos(int i);
        real v;
        v = 127.0 * $cos(real'(i) * 3.14159265358979 / 8.0);
        return int'($floor(v + 0.5));
    endfunction

    function automatic int ref_win(int k);
        int a;
        int b;
        a = (k < 6) ? 32 + 64 * k : 32 + 64 * (11 - k);
        b = 256;
        return (a < b) ? a : b;
    endfunction

    function automatic int ref_g(int p, int k);
        int prod;
        prod = ref_cos((2 * p + 3 * k) % 16) * ref_win(k);
        return prod >>> 8;
    endfunction

    function automatic int ref_step(int t);
        case (t)
            1: return 0;
            0: return 1;
            2: return 2;
            3: return 3;
            7: return 4;
            6: return 5;
            4: return 6;
            default: return 7;
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    // R3 R5 R6: expected six samples of one symbol
    task automatic plan_symbol(int code, bit under, string tag);
        int np;
        int tail;
        int sum;
        exp_t e;
        np = (m_phase + ref_step(code)) % 8;
        for (int s = 0; s < 6; s++) begin
            tail = m_ok ? ref_g(m_phase, s + 6) : 0;
            sum = tail + ref_g(np, s);
            if (sum > 127 || sum < -128) sat_seen++;
            if (sum > 127) sum = 127;
            if (sum < -128) sum = -128;
            e.smp = sum;
            e.first = (s == 0);
            e.under = under;
            e.tag = tag;
            exp_q.push_back(e);
        end
        m_ok = 1;
        m_phase = np;
    endtask

    task automatic send_bit(bit b);
        @(negedge clk);
        while (!bit_rdy_o) @(negedge clk);
        bit_i = b;
        bit_vld_i = 1'b1;
        @(negedge clk);
        bit_vld_i = 1'b0;
    endtask

    task automatic send_tribit(int t);
        send_bit(t[2]);
        send_bit(t[1]);
        send_bit(t[0]);
    endtask

    task automatic strobes(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_stb_i = 1'b1;
            @(negedge clk);
            smp_stb_i = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic symbol(int t, string tag);
        send_tribit(t);
        plan_symbol(t, 0, tag);
        strobes(6);
    endtask

    // monitor: pops one expected item per valid sample (R4 R8)
    always @(negedge clk) begin
        if (!rst && sample_vld_o) begin
            if (exp_q.size() == 0) begin
                check(0, "R8 unexpected sample", int'(sample_o), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(sample_o) == e.smp, {e.tag, " sample"}, int'(sample_o), e.smp);
                check(sym_start_o == e.first, "R4 sym_start", int'(sym_start_o), int'(e.first));
                check(underrun_o == e.under, "R7 underrun", int'(underrun_o), int'(e.under));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        check(0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(sample_o == 0, "R1 sample", int'(sample_o), 0);
        check(sample_vld_o == 0, "R1 vld", int'(sample_vld_o), 0);
        check(sym_start_o == 0, "R1 sym_start", int'(sym_start_o), 0);
        check(underrun_o == 0, "R1 underrun", int'(underrun_o), 0);
        check(bit_rdy_o == 1, "R1 ready", int'(bit_rdy_o), 1);

        // R1 R6: first symbol has no tail, phase from 0
        symbol(3'b011, "R1 first symbol");

        // R2: ready drops once full, offered bits ignored
        send_tribit(3'b110);
        @(negedge clk);
        check(bit_rdy_o == 0, "R2 ready low when full", int'(bit_rdy_o), 0);
        bit_i = 1'b1;
        bit_vld_i = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(bit_rdy_o == 0, "R2 ready held low", int'(bit_rdy_o), 0);
        end
        bit_vld_i = 1'b0;
        plan_symbol(3'b110, 0, "R2 ignored bits");
        strobes(6);

        // R3: every code once
        for (int t = 0; t < 8; t++) symbol(t, "R3 code map");

        // R7: underrun with nothing held
        plan_symbol(1, 1, "R7 empty underrun");
        strobes(6);
        check(bit_rdy_o == 1, "R7 ready after underrun", int'(bit_rdy_o), 1);

        // R7: partial bit kept across underrun
        send_bit(1'b1);
        plan_symbol(1, 1, "R7 partial underrun");
        strobes(6);
        send_bit(1'b0);
        send_bit(1'b1);
        plan_symbol(3'b101, 0, "R7 kept bit leads");
        strobes(6);

        // R5 R6: pseudo-random stream
        lfsr = 8'hA5;
        for (int n = 0; n < 40; n++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            symbol(int'(lfsr[2:0]), "R5 R6 stream");
        end

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4 all samples seen", exp_q.size(), 0);
        check(sat_seen > 0, "R6 saturation exercised", sat_seen, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule